// File: doc/BRIEF.md
# Operand Register-Change Recorder

This block keeps a 16-bit log of the general registers that an instruction's operand decoder has stepped, and by how much. When an instruction aborts part way through, recovery code reads the log to undo each step. A step is reported with a single strobe. The strobe carries a 3-bit register number, an increment or decrement flag and a byte-operand flag, and the block works out the signed step amount from these. Each record packs into one byte. The first record of an instruction goes to the low byte and the second to the high byte.

The log is cleared when an instruction fetch starts and when a trap sequence starts. A freeze input holds the log unchanged so that the contents from an abort survive later activity. A 2-bit feature level selects how a read presents the value: plain, always zero, or with immediate and absolute entries filtered out. Whatever a read presents is also written back into the log.

Top module: `regstep_log`

## Requirements
- R1: Each record byte holds the register number in bits 2:0 and the step amount, a 5-bit two's-complement value, in bits 7:3.
- R2: An increment records +2 for a word operand. For a byte operand it records +1, except on registers 6 and 7, which always record +2.
- R3: A decrement records the negated step masked to 5 bits. A word decrement of -2 gives octal 036 in bits 7:3, and a byte decrement of -1 on registers 0 to 5 gives octal 037.
- R4: A step of register 7 is recorded in the same way as a step of any other register.
- R5: The first record after a clear goes into bits 7:0 and the second into bits 15:8. Further records before the next clear are ignored.
- R6: While freeze is high, records, fetch starts and trap starts leave the log unchanged.
- R7: A trap start with freeze low clears the log to zero on the next clock edge.
- R8: A fetch start with freeze low clears the log to zero on the next clock edge. A clear takes priority over a record in the same cycle, and a record takes priority over a read write-back.
- R9: When the level is 2'b00 (reduced management), the read data is 0 whatever the contents.
- R10: When the level is 2'b10 (filtering), a high byte equal to octal 027 reads as zero. A low byte equal to octal 027 is removed by moving the high byte down into the low byte. Levels 2'b01 and 2'b11 present the log unchanged.
- R11: A read strobe writes the presented value back into the log.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 2 | Feature level: 00 reduced, 01 plain, 10 filtering, 11 plain |
| freeze_i | input | 1 | Holds the log unchanged |
| fetch_i | input | 1 | Instruction fetch start pulse |
| trap_i | input | 1 | Trap sequence start pulse |
| rec_i | input | 1 | Record strobe |
| rec_reg_i | input | 3 | Register that was stepped |
| rec_dec_i | input | 1 | 1 for decrement, 0 for increment |
| rec_byte_i | input | 1 | 1 for a byte operand |
| rd_i | input | 1 | Read strobe, which triggers the write-back |
| rd_data_o | output | 16 | Presented log value |

## Verification
The assertions assume that the feature level is stable around a read. They also assume that a read is not issued in the same cycle as a record or a clear; otherwise the freeze-stability check would also have to cover write-back. The stimulus performs exactly one action per cycle (a record, a clear pulse or a read) and changes the level only together with the read that uses it. Expected values come from a bench model of the requirements, queued by the driver and compared by the monitor at the falling edge of each read cycle.

// File: rtl/regstep_log.sv
module regstep_log #(
  parameter int WIDTH = 16,
  parameter int REGW  = 3,
  parameter int AMTW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       level_i,
  input  logic             freeze_i,
  input  logic             fetch_i,
  input  logic             trap_i,
  input  logic             rec_i,
  input  logic [REGW-1:0]  rec_reg_i,
  input  logic             rec_dec_i,
  input  logic             rec_byte_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int ENTW = REGW + AMTW;
  localparam logic [ENTW-1:0] IMM_KEY = ENTW'(8'o027);

  logic [WIDTH-1:0] log_q, filt;
  logic [1:0]       slot_q;
  logic [AMTW-1:0]  mag, amt;
  logic [ENTW-1:0]  entry;
  logic             clr;

  assign mag   = (rec_byte_i && (rec_reg_i < REGW'(6))) ? AMTW'(1) : AMTW'(2);
  assign amt   = rec_dec_i ? (AMTW'(0) - mag) : mag;
  assign entry = {amt, rec_reg_i};
  assign clr   = (fetch_i || trap_i) && !freeze_i;

  always_comb begin
    filt = log_q;
    if (filt[WIDTH-1:ENTW] == IMM_KEY) filt = {{ENTW{1'b0}}, filt[ENTW-1:0]};
    if (filt[ENTW-1:0] == IMM_KEY)     filt = filt >> ENTW;
    case (level_i)
      2'b00:   rd_data_o = '0;
      2'b10:   rd_data_o = filt;
      default: rd_data_o = log_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_q  <= '0;
      slot_q <= '0;
    end else if (clr) begin
      log_q  <= '0;
      slot_q <= '0;
    end else if (rec_i && !freeze_i) begin
      if (slot_q == 2'd0) begin
        log_q[ENTW-1:0] <= entry;
        slot_q <= 2'd1;
      end else if (slot_q == 2'd1) begin
        log_q[WIDTH-1:ENTW] <= entry;
        slot_q <= 2'd2;
      end
    end else if (rd_i) begin
      log_q <= rd_data_o;
    end
  end

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !rd_i) |=> $stable(log_q));

  // R7
  trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !freeze_i) |=> (log_q == '0));

  // R8
  fetch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !freeze_i) |=> (slot_q == 2'd0));

  // R9
  reduced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == 2'b00) |-> (rd_data_o == '0));

  // R10
  filter_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == 2'b10) |-> (rd_data_o[ENTW-1:0] != IMM_KEY && rd_data_o[WIDTH-1:ENTW] != IMM_KEY));

  // R5
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && !clr && !freeze_i && slot_q == 2'd0) |=> (log_q[REGW-1:0] == $past(rec_reg_i)));

  // R5
  third_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && !clr && slot_q == 2'd2) |=> $stable(log_q));

  // R11
  writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !rec_i && !clr) |=> (log_q == $past(rd_data_o)));
endmodule

// File: tb/regstep_log_tb.sv
`timescale 1ns/1ps
module regstep_log_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] level_i = 2'b01;
  logic freeze_i = 0, fetch_i = 0, trap_i = 0, rec_i = 0, rec_dec_i = 0, rec_byte_i = 0, rd_i = 0;
  logic [2:0] rec_reg_i = 0;
  logic [15:0] rd_data_o;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] model = 0;
  int slot = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  regstep_log u_dut (.clk, .rst_n, .level_i, .freeze_i, .fetch_i, .trap_i, .rec_i,
    .rec_reg_i, .rec_dec_i, .rec_byte_i, .rd_i, .rd_data_o);

  function automatic logic [15:0] present(logic [15:0] v, logic [1:0] lv);
    logic [15:0] f = v;
    if (f[15:8] == 8'o027) f[15:8] = 8'h00;
    if (f[7:0] == 8'o027) f = f >> 8;
    case (lv)
      2'b00: return 16'h0;
      2'b10: return f;
      default: return v;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    rec_i = 0; fetch_i = 0; trap_i = 0; rd_i = 0;
  endtask

  task automatic rec(input logic [2:0] r, input bit dec, input bit byt);
    logic [4:0] m, a;
    m = (byt && r < 6) ? 5'd1 : 5'd2;
    a = dec ? 5'd0 - m : m;
    rec_i = 1; rec_reg_i = r; rec_dec_i = dec; rec_byte_i = byt;
    if (!freeze_i) begin
      if (slot == 0) begin model[7:0] = {a, r}; slot = 1; end
      else if (slot == 1) begin model[15:8] = {a, r}; slot = 2; end
    end
    tick();
  endtask

  task automatic clear(input bit trap);
    if (trap) trap_i = 1; else fetch_i = 1;
    if (!freeze_i) begin model = 0; slot = 0; end
    tick();
  endtask

  task automatic rd_chk(input logic [1:0] lv, input string tag);
    level_i = lv; rd_i = 1;
    exp_q.push_back(present(model, lv));
    tag_q.push_back(tag);
    model = present(model, lv);
    tick();
  endtask

  always @(negedge clk) if (rst_n && rd_i) begin
    logic [15:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    tests++;
    if (rd_data_o !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, rd_data_o, e);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_chk(2'b01, "reset value zero R1");
    clear(0); rec(3'd3, 0, 0); rd_chk(2'b01, "R1 R2 word inc r3 gives 0013");
    clear(0); rec(3'd2, 1, 0); rec(3'd1, 0, 1); rd_chk(2'b01, "R3 R5 dec r2 then byte inc r1");
    clear(0); rec(3'd6, 0, 1); rec(3'd7, 1, 1); rd_chk(2'b01, "R2 R3 byte on r6 r7 step 2");
    clear(0); rec(3'd5, 1, 1); rd_chk(2'b01, "R3 byte dec r5 gives 037");
    clear(0); rec(3'd7, 0, 0); rd_chk(2'b11, "R4 pc inc recorded 027");
    clear(0); rec(3'd0, 0, 0); rec(3'd1, 0, 0); rec(3'd4, 1, 0); rd_chk(2'b01, "R5 third record ignored");
    clear(0); rec(3'd7, 0, 0); rec(3'd2, 0, 0); rd_chk(2'b10, "R10 low 027 shifted out");
    rd_chk(2'b01, "R11 write-back after filter");
    clear(0); rec(3'd4, 1, 1); rec(3'd7, 0, 0); rd_chk(2'b10, "R10 high 027 dropped");
    clear(0); rec(3'd7, 0, 0); rec(3'd7, 0, 0); rd_chk(2'b10, "R10 both bytes 027");
    clear(0); rec(3'd3, 0, 0); rd_chk(2'b00, "R9 reduced reads zero");
    rd_chk(2'b01, "R11 zero written back");
    clear(0); rec(3'd3, 0, 0);
    freeze_i = 1; rec(3'd5, 0, 0); clear(1); clear(0);
    rd_chk(2'b01, "R6 frozen log unchanged");
    freeze_i = 0; clear(1); rd_chk(2'b01, "R7 trap clears");
    rec(3'd6, 1, 0); clear(0); rd_chk(2'b01, "R8 fetch clears");
    rec(3'd2, 0, 0); fetch_i = 1; model = 0; slot = 0; rec(3'd1, 0, 0);
    model = 0; slot = 0; rd_chk(2'b01, "R8 clear beats record");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule